// File: doc/BRIEF.md
# Bit Test and Bit Scan Unit

This unit works on a 16-bit source word. It has two groups of operations. The first group tests one bit. It reads the bit chosen by a 4-bit index into a carry output. It then returns the word either unchanged or with that bit set, cleared or inverted. The second group scans the word for a set bit. It can search upward from bit 0 or downward from bit 15, and it reports the position of the first set bit it meets. A zero flag marks a source that has no set bit.

A caller presents the source, the index and an operation code, and pulses `start_i` for one cycle. One cycle later every result is registered, and `done_o` is high for that one cycle. There is no back-pressure. The unit accepts a start on every cycle, including back-to-back cycles, and it never stalls. Each result stays on the outputs until a later operation replaces it, so the caller can read it at any time after `done_o`.

Top module: `bts_unit`

## Requirements
- R1: For operation codes 0 (plain test), 1 (test-and-set), 2 (test-and-clear) and 3 (test-and-invert), `carry_o` takes the value of source bit `bit_idx_i`. This is the value before any change is made to the bit.
- R2: Code 0 returns the source on `result_o` with no bit changed.
- R3: Code 1 returns the source with the indexed bit forced to 1. Code 2 forces that bit to 0. Code 3 inverts that bit. All other bits are returned unchanged.
- R4: Code 4 (upward scan) writes the position of the lowest set bit of the source to `scan_idx_o`.
- R5: Code 5 (downward scan) writes the position of the highest set bit of the source to `scan_idx_o`.
- R6: After a scan, `zero_o` is 1 when the source was all zeros and 0 otherwise.
- R7: A scan of an all-zero source leaves `scan_idx_o` at its previous value.
- R8: A test operation (codes 0 to 3) leaves `zero_o` and `scan_idx_o` unchanged. A scan leaves `carry_o` unchanged and returns the source unchanged on `result_o`.
- R9: `done_o` is high in exactly the cycle after each cycle in which `start_i` is high, and low in every other cycle. Without a start, no output changes.
- R10: Codes 6 and 7 still pulse `done_o`, but they leave `result_o`, `carry_o`, `scan_idx_o` and `zero_o` unchanged.
- R11: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts one operation using the current inputs |
| op_i | input | 3 | Operation code (0 to 5; 6 and 7 are not used) |
| bit_idx_i | input | 4 | Bit position for the test operations |
| src_i | input | 16 | Source word |
| result_o | output | 16 | Returned word |
| carry_o | output | 1 | Tested bit |
| scan_idx_o | output | 4 | Position found by a scan |
| zero_o | output | 1 | All-zero source flag for scans |
| done_o | output | 1 | One-cycle pulse when results update |

## Verification
Every piece of state in this unit is a port register, so any wrong update shows at the ports in the cycle after the start that caused it. A scan that reaches the wrong end of the word, or a scan that clobbers the held index on an all-zero source, shows directly on `scan_idx_o`. A stale or wrongly written flag lasts until the next operation of the other kind, so the bench checks every field after every operation. Writing mixed test and scan operations in sequence exposes any register that updates when its operation should leave it alone.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [2:0] {
    OP_TEST   = 3'd0,
    OP_SET    = 3'd1,
    OP_CLEAR  = 3'd2,
    OP_INVERT = 3'd3,
    OP_SCANUP = 3'd4,
    OP_SCANDN = 3'd5
  } bts_op_e;
endpackage

// File: rtl/bts_bit_modify.sv
module bts_bit_modify #(
  parameter int WIDTH = 16,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] res_o,
  output logic             bit_o
);
  logic [WIDTH-1:0] mask;

  always_comb begin
    mask  = {{(WIDTH-1){1'b0}}, 1'b1} << idx_i;
    bit_o = src_i[idx_i];
    unique case (mode_i)
      2'd0:    res_o = src_i;
      2'd1:    res_o = src_i | mask;
      2'd2:    res_o = src_i & ~mask;
      default: res_o = src_i ^ mask;
    endcase
  end
endmodule

// File: rtl/bts_scan.sv
module bts_scan #(
  parameter int WIDTH   = 16,
  parameter bit REVERSE = 1'b0,
  localparam int IDX_W  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  assign any_o = |src_i;

  generate
    if (REVERSE) begin : g_down
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < WIDTH; i++)
          if (src_i[i]) idx_o = i[IDX_W-1:0];
      end
    end else begin : g_up
      always_comb begin
        idx_o = '0;
        for (int i = WIDTH-1; i >= 0; i--)
          if (src_i[i]) idx_o = i[IDX_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/bts_unit.sv
module bts_unit
  import bts_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic [IDX_W-1:0] scan_idx_o,
  output logic             zero_o,
  output logic             done_o
);
  bts_op_e          op;
  logic [WIDTH-1:0] mod_res;
  logic             tested_bit;
  logic [IDX_W-1:0] up_idx, dn_idx;
  logic             up_any, dn_any;
  logic             is_test, is_scan;

  assign op      = bts_op_e'(op_i);
  assign is_test = (op_i[2] == 1'b0);
  assign is_scan = (op == OP_SCANUP) || (op == OP_SCANDN);

  bts_bit_modify #(.WIDTH(WIDTH)) u_modify (
    .src_i(src_i), .idx_i(bit_idx_i), .mode_i(op_i[1:0]),
    .res_o(mod_res), .bit_o(tested_bit)
  );

  bts_scan #(.WIDTH(WIDTH), .REVERSE(1'b0)) u_scan_up (
    .src_i(src_i), .idx_o(up_idx), .any_o(up_any)
  );

  bts_scan #(.WIDTH(WIDTH), .REVERSE(1'b1)) u_scan_dn (
    .src_i(src_i), .idx_o(dn_idx), .any_o(dn_any)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      result_o   <= '0;
      carry_o    <= 1'b0;
      scan_idx_o <= '0;
      zero_o     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i && is_test) begin
        result_o <= mod_res;
        carry_o  <= tested_bit;
      end else if (start_i && is_scan) begin
        result_o <= src_i;
        if (op == OP_SCANUP) begin
          zero_o <= ~up_any;
          if (up_any) scan_idx_o <= up_idx;
        end else begin
          zero_o <= ~dn_any;
          if (dn_any) scan_idx_o <= dn_idx;
        end
      end
    end
  end

  // R9
  done_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  // R9
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o && $stable(result_o) && $stable(carry_o));
  // R2
  plain_test_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd0) |=> result_o == $past(src_i));
  // R8
  test_keeps_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i[2]) |=> $stable(zero_o) && $stable(scan_idx_o));
  // R8
  scan_keeps_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i[2] && !op_i[1]) |=> $stable(carry_o));
  // R7
  zero_scan_holds_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i[2] && !op_i[1] && src_i == '0) |=> $stable(scan_idx_o) && zero_o);
  // R10
  unused_code_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i[2] && op_i[1]) |=> $stable(result_o) && $stable(carry_o)
      && $stable(zero_o) && $stable(scan_idx_o));
endmodule

// File: tb/bts_unit_tb.sv
module bts_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [3:0]  bidx = '0;
  logic [15:0] src = '0;
  logic [15:0] result;
  logic        carry, zero, done;
  logic [3:0]  sidx;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bts_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .bit_idx_i(bidx), .src_i(src), .result_o(result), .carry_o(carry),
    .scan_idx_o(sidx), .zero_o(zero), .done_o(done)
  );

  // {op, bit idx, source, exp result, exp carry, exp scan idx, exp zero}
  localparam int NV = 18;
  localparam logic [44:0] VEC [NV] = '{
    {3'd0, 4'd3,  16'h0008, 16'h0008, 1'b1, 4'd0,  1'b0},
    {3'd1, 4'd0,  16'h1234, 16'h1235, 1'b0, 4'd0,  1'b0},
    {3'd2, 4'd15, 16'h8001, 16'h0001, 1'b1, 4'd0,  1'b0},
    {3'd3, 4'd4,  16'h00F0, 16'h00E0, 1'b1, 4'd0,  1'b0},
    {3'd3, 4'd8,  16'h0000, 16'h0100, 1'b0, 4'd0,  1'b0},
    {3'd4, 4'd0,  16'h0120, 16'h0120, 1'b0, 4'd5,  1'b0},
    {3'd5, 4'd0,  16'h0120, 16'h0120, 1'b0, 4'd8,  1'b0},
    {3'd4, 4'd0,  16'h0000, 16'h0000, 1'b0, 4'd8,  1'b1},
    {3'd5, 4'd0,  16'h8000, 16'h8000, 1'b0, 4'd15, 1'b0},
    {3'd0, 4'd2,  16'hFFFF, 16'hFFFF, 1'b1, 4'd15, 1'b0},
    {3'd5, 4'd0,  16'h0000, 16'h0000, 1'b1, 4'd15, 1'b1},
    {3'd1, 4'd7,  16'h0000, 16'h0080, 1'b0, 4'd15, 1'b1},
    {3'd4, 4'd0,  16'h0001, 16'h0001, 1'b0, 4'd0,  1'b0},
    {3'd6, 4'd1,  16'hAAAA, 16'h0001, 1'b0, 4'd0,  1'b0},
    {3'd4, 4'd0,  16'hFFFF, 16'hFFFF, 1'b0, 4'd0,  1'b0},
    {3'd5, 4'd0,  16'hFFFF, 16'hFFFF, 1'b0, 4'd15, 1'b0},
    {3'd7, 4'd9,  16'h5555, 16'hFFFF, 1'b0, 4'd15, 1'b0},
    {3'd3, 4'd15, 16'h8000, 16'h0000, 1'b1, 4'd15, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0:    return "R1 R2 R8";
      3'd1, 3'd2, 3'd3: return "R1 R3 R8";
      3'd4:    return "R4 R6 R7 R8";
      3'd5:    return "R5 R6 R7 R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 result", 32'(result), 0);
    chk("R11 carry", 32'(carry), 0);
    chk("R11 idx", 32'(sidx), 0);
    chk("R11 zero", 32'(zero), 0);
    chk("R11 done", 32'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [44:0] v;
      v = VEC[k];
      start = 1'b1; op = v[44:42]; bidx = v[41:38]; src = v[37:22];
      @(negedge clk);
      start = 1'b0;
      chk({tag_of(v[44:42]), " result"}, 32'(result), 32'(v[21:6]));
      chk({tag_of(v[44:42]), " carry"},  32'(carry),  32'(v[5]));
      chk({tag_of(v[44:42]), " idx"},    32'(sidx),   32'(v[4:1]));
      chk({tag_of(v[44:42]), " zero"},   32'(zero),   32'(v[0]));
      chk("R9 done pulse", 32'(done), 1);
    end

    // R9: done drops, and idle inputs change nothing
    op = 3'd1; bidx = 4'd3; src = 16'h1111;
    @(negedge clk);
    chk("R9 done low", 32'(done), 0);
    chk("R9 idle result", 32'(result), 32'h0000);
    chk("R9 idle carry", 32'(carry), 1);

    // R9: back-to-back starts keep done high each cycle
    start = 1'b1; op = 3'd0; src = 16'h0004; bidx = 4'd2;
    @(negedge clk);
    chk("R9 b2b done 1", 32'(done), 1);
    chk("R1 b2b carry 1", 32'(carry), 1);
    op = 3'd4; src = 16'h0400;
    @(negedge clk);
    start = 1'b0;
    chk("R9 b2b done 2", 32'(done), 1);
    chk("R4 b2b idx", 32'(sidx), 10);
    chk("R8 b2b carry held", 32'(carry), 1);
    @(negedge clk);
    chk("R9 b2b done off", 32'(done), 0);

    // R11: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 re-reset result", 32'(result), 0);
    chk("R11 re-reset idx", 32'(sidx), 0);
    chk("R11 re-reset carry", 32'(carry), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule